// File: doc/BRIEF.md
# PCI Type 0 Configuration Header Registers

This block holds the software-visible Type 0 configuration header of a PCI target function. It sits beside a hard target core, which turns configuration cycles on the bus into a dword index, a write strobe, write data and active-low byte enables. A configuration read sees the addressed dword on a combinational read-data bus. The bus holds that value for as long as the index is held, so the core can take it in whatever cycle it drives TRDY.

The block keeps the Command register and the Status register, and it holds two Base Address Registers. BAR 0 is a memory BAR and BAR 1 is an I/O BAR. The identity words are fixed parameters. The block drives the command enables as live outputs: the address decoder uses the I/O and memory enables, and the target core uses the parity-response and SERR enables. Two event pulses from the core set sticky error flags in Status, and software clears these flags by writing 1 to them. Software finds the size of each BAR the usual way: it writes all ones and reads the value back.

Top module: `cfg_space`

## Requirements
- R1: After reset, the Command register, the two Status error flags and both BAR base fields are zero. io_en, mem_en, perr_resp and serr_en are low.
- R2: Index 0 reads {DEVICE_ID, VENDOR_ID}. Index 2 reads {CLASS_CODE, REVISION_ID}. Writes to either index do not change them.
- R3: A write to index 1 updates Command bits [15:0] through byte lanes 0 and 1, where be_n[k] low enables bits [8k+7:8k]. Only the bits set in CMD_WMASK (default bits 0, 1, 2, 6 and 8) can be written. All other Command bits read as 0.
- R4: io_en, mem_en, perr_resp and serr_en equal Command bits 0, 1, 6 and 8. They change in the cycle after the write that changes those bits.
- R5: A high par_err_evt sets Status bit 15, which reads as bit 31 of index 1, one cycle later. The bit stays set until software clears it.
- R6: A high sys_err_evt sets Status bit 14, which reads as bit 30 of index 1, one cycle later. The bit stays set until software clears it.
- R7: A write to index 1 with be_n[3] low clears each Status error bit whose write-data bit (31 or 30) is 1. Writing 0 to a bit, or writing with be_n[3] high, leaves the bit unchanged.
- R8: When a set event and a clearing write hit the same Status bit in the same cycle, the bit ends up set.
- R9: BAR 0 at index 4 is a 32-bit memory BAR. Read bits [BAR0_SIZE_LOG2-1:0] are always 0, and writable bits merge by byte lane. Writing all ones reads back ~(2^BAR0_SIZE_LOG2 - 1).
- R10: BAR 1 at index 5 is an I/O BAR. Read bit 0 is always 1 and read bits [BAR1_SIZE_LOG2-1:1] are always 0. Writing all ones reads back ~(2^BAR1_SIZE_LOG2 - 1) | 1.
- R11: bar0 and bar1 always equal the values that reads of index 4 and index 5 return.
- R12: Every index other than 0, 1, 2, 4 and 5 reads as zero. A write there changes no register.
- R13: No register changes while cfg_we is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_idx | input | IDX_W (8) | Configuration dword index (byte offset / 4) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be_n | input | 4 | Active-low byte enables |
| cfg_we | input | 1 | Configuration write strobe |
| par_err_evt | input | 1 | Parity error detected pulse from the core |
| sys_err_evt | input | 1 | System error signalled pulse from the core |
| cfg_rdata | output | 32 | Dword at cfg_idx, combinational |
| io_en | output | 1 | Command bit 0, I/O space enable |
| mem_en | output | 1 | Command bit 1, memory space enable |
| perr_resp | output | 1 | Command bit 6, parity error response |
| serr_en | output | 1 | Command bit 8, SERR enable |
| bar0 | output | 32 | Current BAR 0 value |
| bar1 | output | 32 | Current BAR 1 value |

## Verification
Read data depends only on the index and the current register state, so it is due in the same cycle that the index is applied. The bench drives every input on the falling edge and compares cfg_rdata a nanosecond later, before the next rising edge. Writes, error events and clears take effect at that rising edge. The bench applies each one to its model only after the edge, so the comparison on the next falling edge sees the register one cycle after the stimulus. The exported enables and BAR outputs follow the same one-cycle rule, and the bench checks them in the same sample window.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int DWORD_W = 32;
  localparam int LANES   = DWORD_W / 8;

  // Expand active-low byte enables into a bit mask of enabled lanes.
  function automatic logic [DWORD_W-1:0] lane_mask(input logic [LANES-1:0] be_n);
    logic [DWORD_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{~be_n[i]}};
    return m;
  endfunction

  // Merge new data into old under lane enables and a per-bit write mask.
  function automatic logic [DWORD_W-1:0] merge_bytes(
    input logic [DWORD_W-1:0] old_v,
    input logic [DWORD_W-1:0] new_v,
    input logic [LANES-1:0]   be_n,
    input logic [DWORD_W-1:0] wmask
  );
    logic [DWORD_W-1:0] m;
    m = lane_mask(be_n) & wmask;
    return (old_v & ~m) | (new_v & m);
  endfunction

  // Writable base bits of a BAR of 2**size_log2 bytes.
  function automatic logic [DWORD_W-1:0] bar_base_mask(input int size_log2, input bit is_io);
    logic [DWORD_W-1:0] m;
    m = {DWORD_W{1'b1}} << size_log2;
    if (is_io) m = m & ~32'h0000_0003;
    else       m = m & ~32'h0000_000F;
    return m;
  endfunction

  // Hard-wired low attribute bits of a BAR (I/O space indicator).
  function automatic logic [DWORD_W-1:0] bar_attr_bits(input bit is_io);
    return is_io ? 32'h0000_0001 : 32'h0000_0000;
  endfunction

endpackage

// File: rtl/cfg_cmd_status.sv
module cfg_cmd_status
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] CMD_WMASK = 16'h0147
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [DWORD_W-1:0] wdata,
  input  logic [LANES-1:0]   be_n,
  input  logic               par_err_evt,
  input  logic               sys_err_evt,
  output logic [15:0]        cmd_q,
  output logic [15:0]        stat_q
);

  logic        det_pe_q, sig_se_q;
  logic        clr_pe, clr_se;
  logic [15:0] cmd_next;

  // Clear requests (write-one-to-clear through byte lane 3).
  assign clr_pe = wr_hit && !be_n[3] && wdata[31];
  assign clr_se = wr_hit && !be_n[3] && wdata[30];

  always_comb begin
    logic [DWORD_W-1:0] merged;
    merged   = merge_bytes({16'h0, cmd_q}, wdata, be_n, {16'h0, CMD_WMASK});
    cmd_next = merged[15:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      det_pe_q <= 1'b0;
      sig_se_q <= 1'b0;
    end else begin
      if (wr_hit) cmd_q <= cmd_next;
      det_pe_q <= par_err_evt | (det_pe_q & ~clr_pe);
      sig_se_q <= sys_err_evt | (sig_se_q & ~clr_se);
    end
  end

  assign stat_q = {det_pe_q, sig_se_q, 14'h0000};

  p_pe_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_evt |=> det_pe_q);
  p_se_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err_evt |=> sig_se_q);
  p_pe_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (det_pe_q && !clr_pe) |=> det_pe_q);
  p_pe_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pe && !par_err_evt) |=> !det_pe_q);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_se && sys_err_evt) |=> sig_se_q);
  p_cmd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(cmd_q));

endmodule

// File: rtl/cfg_bar.sv
module cfg_bar
  import cfg_space_pkg::*;
#(
  parameter int SIZE_LOG2 = 12,
  parameter bit IS_IO     = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [DWORD_W-1:0] wdata,
  input  logic [LANES-1:0]   be_n,
  output logic [DWORD_W-1:0] bar_val
);

  localparam logic [DWORD_W-1:0] BASE_MASK = bar_base_mask(SIZE_LOG2, IS_IO);
  localparam logic [DWORD_W-1:0] ATTR      = bar_attr_bits(IS_IO);

  logic [DWORD_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      base_q <= '0;
    else if (wr_hit) base_q <= merge_bytes(base_q, wdata, be_n, BASE_MASK);
  end

  assign bar_val = (base_q & BASE_MASK) | ATTR;

  p_bar_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(bar_val));
  p_bar_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((bar_val & ~BASE_MASK) == ATTR));

endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_space_pkg::*;
#(
  parameter int          IDX_W       = 8,
  parameter logic [15:0] VENDOR_ID   = 16'h1AB5,
  parameter logic [15:0] DEVICE_ID   = 16'h7C02,
  parameter logic [7:0]  REVISION_ID = 8'h03,
  parameter logic [23:0] CLASS_CODE  = 24'h118000
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic [15:0]        cmd,
  input  logic [15:0]        stat,
  input  logic [DWORD_W-1:0] bar0,
  input  logic [DWORD_W-1:0] bar1,
  output logic [DWORD_W-1:0] rdata
);

  always_comb begin
    unique case (idx)
      IDX_W'(0): rdata = {DEVICE_ID, VENDOR_ID};
      IDX_W'(1): rdata = {stat, cmd};
      IDX_W'(2): rdata = {CLASS_CODE, REVISION_ID};
      IDX_W'(4): rdata = bar0;
      IDX_W'(5): rdata = bar1;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/cfg_space.sv
module cfg_space
  import cfg_space_pkg::*;
#(
  parameter int          IDX_W         = 8,
  parameter logic [15:0] VENDOR_ID     = 16'h1AB5,
  parameter logic [15:0] DEVICE_ID     = 16'h7C02,
  parameter logic [7:0]  REVISION_ID   = 8'h03,
  parameter logic [23:0] CLASS_CODE    = 24'h118000,
  parameter logic [15:0] CMD_WMASK     = 16'h0147,
  parameter int          BAR0_SIZE_LOG2 = 12,
  parameter int          BAR1_SIZE_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [31:0]      cfg_wdata,
  input  logic [3:0]       cfg_be_n,
  input  logic             cfg_we,
  input  logic             par_err_evt,
  input  logic             sys_err_evt,
  output logic [31:0]      cfg_rdata,
  output logic             io_en,
  output logic             mem_en,
  output logic             perr_resp,
  output logic             serr_en,
  output logic [31:0]      bar0,
  output logic [31:0]      bar1
);

  localparam int NUM_BARS = 2;
  localparam int BAR_IDX0 = 4;

  logic [15:0]                      cmd_q, stat_q;
  logic                             cmd_wr_hit;
  logic [NUM_BARS-1:0]              bar_wr_hit;
  logic [NUM_BARS-1:0][DWORD_W-1:0] bar_vals;
  logic                             idx_mapped;

  assign cmd_wr_hit = cfg_we && (cfg_idx == IDX_W'(1));
  assign idx_mapped = (cfg_idx == IDX_W'(0)) || (cfg_idx == IDX_W'(1)) ||
                      (cfg_idx == IDX_W'(2)) || (cfg_idx == IDX_W'(4)) ||
                      (cfg_idx == IDX_W'(5));

  cfg_cmd_status #(.CMD_WMASK(CMD_WMASK)) u_cmd_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_hit      (cmd_wr_hit),
    .wdata       (cfg_wdata),
    .be_n        (cfg_be_n),
    .par_err_evt (par_err_evt),
    .sys_err_evt (sys_err_evt),
    .cmd_q       (cmd_q),
    .stat_q      (stat_q)
  );

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
    localparam int SZ    = (g == 0) ? BAR0_SIZE_LOG2 : BAR1_SIZE_LOG2;
    localparam bit IS_IO = (g == 1);
    assign bar_wr_hit[g] = cfg_we && (cfg_idx == IDX_W'(BAR_IDX0 + g));
    cfg_bar #(.SIZE_LOG2(SZ), .IS_IO(IS_IO)) u_bar (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (bar_wr_hit[g]),
      .wdata   (cfg_wdata),
      .be_n    (cfg_be_n),
      .bar_val (bar_vals[g])
    );
  end

  cfg_rd_mux #(
    .IDX_W(IDX_W), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .REVISION_ID(REVISION_ID), .CLASS_CODE(CLASS_CODE)
  ) u_rd_mux (
    .idx   (cfg_idx),
    .cmd   (cmd_q),
    .stat  (stat_q),
    .bar0  (bar_vals[0]),
    .bar1  (bar_vals[1]),
    .rdata (cfg_rdata)
  );

  assign io_en     = cmd_q[0];
  assign mem_en    = cmd_q[1];
  assign perr_resp = cmd_q[6];
  assign serr_en   = cmd_q[8];
  assign bar0      = bar_vals[0];
  assign bar1      = bar_vals[1];

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_mapped |-> (cfg_rdata == 32'h0));
  p_unmapped_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !idx_mapped) |=> ($stable(cmd_q) && $stable(bar_vals)));
  p_bar_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx == IDX_W'(4)) |-> (cfg_rdata == bar0));

endmodule

// File: tb/cfg_space_tb.sv
`timescale 1ns/1ps
module cfg_space_tb;

  localparam int          IDX_W = 8;
  localparam logic [15:0] VID   = 16'h1AB5;
  localparam logic [15:0] DID   = 16'h7C02;
  localparam logic [7:0]  RID   = 8'h03;
  localparam logic [23:0] CC    = 24'h118000;
  localparam logic [15:0] CMASK = 16'h0147;
  localparam int          B0SZ  = 12;
  localparam int          B1SZ  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be_n = 4'hF;
  logic cfg_we = 1'b0, par_err_evt = 1'b0, sys_err_evt = 1'b0;
  logic [31:0] cfg_rdata, bar0, bar1;
  logic io_en, mem_en, perr_resp, serr_en;

  int n_cmp = 0;
  int n_bad = 0;

  // Bench model state
  logic [15:0] m_cmd;
  logic        m_pe, m_se;
  logic [31:0] m_b0, m_b1;

  always #2 clk = ~clk;

  cfg_space #(
    .IDX_W(IDX_W), .VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION_ID(RID),
    .CLASS_CODE(CC), .CMD_WMASK(CMASK), .BAR0_SIZE_LOG2(B0SZ), .BAR1_SIZE_LOG2(B1SZ)
  ) u_dut (.*);

  function automatic logic [31:0] be_bits(input logic [3:0] be_n);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) if (!be_n[k]) r[k*8 +: 8] = 8'hFF;
    return r;
  endfunction

  function automatic logic [31:0] b0_view(input logic [31:0] base);
    return base & ((32'hFFFF_FFFF >> B0SZ) << B0SZ);
  endfunction

  function automatic logic [31:0] b1_view(input logic [31:0] base);
    return (base & ((32'hFFFF_FFFF >> B1SZ) << B1SZ)) | 32'h1;
  endfunction

  function automatic logic [31:0] exp_read(input logic [IDX_W-1:0] i);
    case (i)
      8'd0:    return {DID, VID};
      8'd1:    return {m_pe, m_se, 14'h0, m_cmd};
      8'd2:    return {CC, RID};
      8'd4:    return b0_view(m_b0);
      8'd5:    return b1_view(m_b1);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " rdata"}, cfg_rdata, exp_read(cfg_idx));
    check("R4 enables", {28'h0, serr_en, perr_resp, mem_en, io_en},
          {28'h0, m_cmd[8], m_cmd[6], m_cmd[1], m_cmd[0]});
    check("R11 bar0", bar0, b0_view(m_b0));
    check("R11 bar1", bar1, b1_view(m_b1));
  endtask

  // One cycle: drive on falling edge, check before the rising edge, update model after it.
  task automatic step(input string req, input logic [IDX_W-1:0] i, input logic [31:0] wd,
                      input logic [3:0] be, input logic we, input logic pe, input logic se);
    logic [31:0] bm;
    @(negedge clk);
    cfg_idx = i; cfg_wdata = wd; cfg_be_n = be; cfg_we = we;
    par_err_evt = pe; sys_err_evt = se;
    #1;
    check_all(req);
    @(posedge clk);
    bm = be_bits(be);
    if (we && i == 8'd1)
      m_cmd = (m_cmd & ~(bm[15:0] & CMASK)) | (wd[15:0] & bm[15:0] & CMASK);
    m_pe = pe | (m_pe & ~(we && i == 8'd1 && !be[3] && wd[31]));
    m_se = se | (m_se & ~(we && i == 8'd1 && !be[3] && wd[30]));
    if (we && i == 8'd4) m_b0 = (m_b0 & ~bm) | (wd & bm);
    if (we && i == 8'd5) m_b1 = (m_b1 & ~bm) | (wd & bm);
  endtask

  initial begin
    #150000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_cmd = '0; m_pe = 0; m_se = 0; m_b0 = '0; m_b1 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state of every register and output
    for (int i = 0; i < 8; i++) step("R1 reset", IDX_W'(i), 0, 4'hF, 0, 0, 0);
    // R2: identity words ignore writes
    step("R2 write id0", 8'd0, 32'hFFFF_FFFF, 4'h0, 1, 0, 0);
    step("R2 id0", 8'd0, 0, 4'hF, 0, 0, 0);
    step("R2 write id2", 8'd2, 32'hFFFF_FFFF, 4'h0, 1, 0, 0);
    step("R2 id2", 8'd2, 0, 4'hF, 0, 0, 0);
    // R3/R4: full-ones command write, then lane 1 only
    step("R3 cmd all", 8'd1, 32'h0000_FFFF, 4'h0, 1, 0, 0);
    step("R3 cmd mask", 8'd1, 0, 4'hF, 0, 0, 0);
    step("R3 lane1 only", 8'd1, 32'h0000_0000, 4'hD, 1, 0, 0);
    step("R4 serr off", 8'd1, 0, 4'hF, 0, 0, 0);
    // R13: strobe low with data present
    step("R13 no strobe", 8'd1, 32'h0000_0000, 4'h0, 0, 0, 0);
    step("R13 hold", 8'd1, 0, 4'hF, 0, 0, 0);
    // R5/R6: error pulses and stickiness
    step("R5 pe pulse", 8'd1, 0, 4'hF, 0, 1, 0);
    step("R5 pe set", 8'd1, 0, 4'hF, 0, 0, 1);
    step("R6 se set", 8'd1, 0, 4'hF, 0, 0, 0);
    // R7: zero-write and lane-3-disabled write leave bits, then clear pe only
    step("R7 write zero", 8'd1, 32'h0000_0000, 4'h0, 1, 0, 0);
    step("R7 lane off", 8'd1, 32'hC000_0000, 4'h8, 1, 0, 0);
    step("R7 clear pe", 8'd1, 32'h8000_0000, 4'h7, 1, 0, 0);
    step("R7 after clear", 8'd1, 0, 4'hF, 0, 0, 0);
    // R8: set and clear collide
    step("R8 collide", 8'd1, 32'hC000_0000, 4'h7, 1, 1, 1);
    step("R8 set wins", 8'd1, 0, 4'hF, 0, 0, 0);
    step("R7 clear both", 8'd1, 32'hC000_0000, 4'h7, 1, 0, 0);
    // R9/R10: BAR sizing probes
    step("R9 bar0 ones", 8'd4, 32'hFFFF_FFFF, 4'h0, 1, 0, 0);
    step("R9 bar0 size", 8'd4, 0, 4'hF, 0, 0, 0);
    check("R9 bar0 size value", bar0, 32'hFFFF_F000);
    step("R10 bar1 ones", 8'd5, 32'hFFFF_FFFF, 4'h0, 1, 0, 0);
    step("R10 bar1 size", 8'd5, 0, 4'hF, 0, 0, 0);
    check("R10 bar1 size value", bar1, 32'hFFFF_FF01);
    step("R9 bar0 lane", 8'd4, 32'h1234_5678, 4'h7, 1, 0, 0);
    step("R9 bar0 lane rd", 8'd4, 0, 4'hF, 0, 0, 0);
    // R12: unmapped writes and reads
    step("R12 wr unmapped", 8'd3, 32'hFFFF_FFFF, 4'h0, 1, 0, 0);
    step("R12 wr unmapped", 8'hFF, 32'hFFFF_FFFF, 4'h0, 1, 0, 0);
    step("R12 rd unmapped", 8'hFF, 0, 4'hF, 0, 0, 0);
    step("R12 rd 6", 8'd6, 0, 4'hF, 0, 0, 0);
    // Random traffic, concentrated on mapped indices
    for (int n = 0; n < 3000; n++) begin
      logic [IDX_W-1:0] ri;
      int pick;
      pick = $urandom_range(0, 9);
      ri = (pick < 8) ? IDX_W'(pick) : IDX_W'($urandom);
      step("R3 R5 R6 R7 R9 R10 R12 random", ri, $urandom, 4'($urandom),
           ($urandom_range(0, 2) == 0), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 7) == 0));
    end
    // R1: reset again mid-run clears state
    @(negedge clk); rst_n = 1'b0; cfg_we = 1'b0; par_err_evt = 0; sys_err_evt = 0;
    @(posedge clk);
    m_cmd = '0; m_pe = 0; m_se = 0; m_b0 = '0; m_b1 = '0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 6; i++) step("R1 re-reset", IDX_W'(i), 0, 4'hF, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule